// File: doc/BRIEF.md
# Ramp Controller Configuration Register File

This block is the register-side slave of a hardware voltage/frequency ramp controller. It holds the configuration words that software loads through a simple valid/ready register bus: eight frequency-scaling slot words, three limits slot words, one link slot word and one ramp-control word. It also holds a command register with a root-enable bit and a self-clearing busy flag, and a configuration-update register through which software commits single entries.

A commit has two phases. Software stores an entry number in the update register and then sets the update-enable bit. On that rising enable the block copies the shadow word that belongs to the entry into the committed outputs. After a programmable number of cycles it sets the one-hot acknowledge bit of that entry. The acknowledge stays set until software writes the update register with the enable bit clear, and that write drops it. The ramp machinery that consumes the committed words is outside the block. Only the committed words are exposed.

The bus is always ready. Each accepted read returns its data one cycle later on a registered response.

Top module: `ramp_cfg_regs`

## Requirements
- R1: After reset every register reads zero, all committed outputs are zero and `rsp_valid` is low.
- R2: The shadow words are readable and writable at byte offsets 0x10-0x2C (frequency words 0..7), 0x30-0x38 (limits words 0..2), 0x40 (link word) and 0x50 (ramp word). A read accepted on a clock edge returns its data with `rsp_valid` high in the cycle after that edge.
- R3: Unaligned addresses, and aligned offsets that map to no register (for example 0x04-0x0C, 0x3C, 0x44-0x4C, 0x54-0x5C, 0x64, 0x68, 0x6C-0x7C), read as zero. Writes to them change no register and no committed output.
- R4: At offset 0x00, bit 1 is a read/write root enable and bit 0 is a read-only busy flag. A write that takes root from 0 to 1 sets busy for BUSY_CYC cycles: reads accepted 1..BUSY_CYC edges after that write see bit 0 set, and later reads see it clear. Writing root as 1 when it is already 1 starts no busy window.
- R5: The update register at offset 0x60 stores the entry number in bits 3:0 and the enable in bit 8. Bits 15:9 and 7:4 read zero, and bits 31:16 (acknowledge) cannot be written.
- R6: A write to 0x60 with bit 8 set while the stored enable is clear copies the shadow word of the entry to the committed output, visible right after the write's edge. Entry 14-k selects frequency word k (k=0..7), entry 6-k selects limits word k (k=0..2), entry 3 the link word and entry 2 the ramp word. Output `cfg_commit` carries word index i at bits [32*i+31:32*i], with indices 0-7 for frequency, 8-10 for limits, 11 for link and 12 for ramp.
- R7: ACK_LAT edges after the commit write, acknowledge bit 16+n of the committed entry n is set, so it is seen by reads accepted ACK_LAT+1 or more edges after the write. It stays set while the enable stays set.
- R8: A write to 0x60 with bit 8 clear clears the acknowledge field and cancels an acknowledge still pending, so the next read shows zero in bits 31:16.
- R9: A write to 0x60 with bit 8 set while the stored enable is already set updates the stored entry number only. It makes no commit and does not restart or redirect the pending acknowledge.
- R10: Entries 0, 1 and 15 have no shadow word. Committing them changes no committed output, but they are still acknowledged on bit 16+n.
- R11: Committed outputs change only on a commit. Later writes to shadow words leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the accepted read |
| rsp_rdata | output | 32 | Read data |
| cfg_commit | output | 416 | Committed configuration words, 13 x 32 bits |

## Verification
Read data is due one cycle after the accepting edge. Committed words are due immediately after the edge that takes the commit write. The acknowledge appears first in a read accepted ACK_LAT+1 edges after that write, and busy shows in reads accepted 1 to BUSY_CYC edges after a root-enable write. The bench drives on the falling edge and samples on the next falling edge. It issues back-to-back reads after each trigger, so that the k-th read is accepted exactly k edges after it, and compares each read with a reference model indexed by k, covering both sides of every latency boundary.

// File: rtl/rcfg_pkg.sv
`timescale 1ns/1ps
package rcfg_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 7;
  parameter int N_FREQ = 8;
  parameter int N_LIM  = 3;
  parameter int N_LINK = 1;

  localparam int N_WORD   = N_FREQ + N_LIM + N_LINK + 1;
  localparam int IDX_W    = $clog2(N_WORD);
  localparam int ENT_W    = 4;
  localparam int ACK_W    = 1 << ENT_W;
  localparam int ACK_LSB  = 16;
  localparam int GO_BIT   = 8;

  localparam int OFF_CMD  = 'h00;
  localparam int OFF_FREQ = 'h10;
  localparam int OFF_LIM  = 'h30;
  localparam int OFF_LINK = 'h40;
  localparam int OFF_RAMP = 'h50;
  localparam int OFF_UPD  = 'h60;

  localparam int W_FREQ = OFF_FREQ / 4;
  localparam int W_LIM  = OFF_LIM / 4;
  localparam int W_LINK = OFF_LINK / 4;
  localparam int W_RAMP = OFF_RAMP / 4;

  localparam int IDX_LIM  = N_FREQ;
  localparam int IDX_LINK = N_FREQ + N_LIM;
  localparam int IDX_RAMP = IDX_LINK + N_LINK;

  // Entry numbering counts down from the top entry of each table.
  localparam int ENT_FREQ_TOP = 14;
  localparam int ENT_LIM_TOP  = 6;
  localparam int ENT_LINK_TOP = 3;
  localparam int ENT_RAMP     = 2;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  function automatic slot_t addr_slot(input logic [ADDR_W-1:0] a);
    slot_t s;
    int    w;
    s = '0;
    w = int'(a[ADDR_W-1:2]);
    if (a[1:0] == 2'b00) begin
      if (w >= W_FREQ && w < W_FREQ + N_FREQ) begin
        s.hit = 1'b1; s.idx = IDX_W'(w - W_FREQ);
      end else if (w >= W_LIM && w < W_LIM + N_LIM) begin
        s.hit = 1'b1; s.idx = IDX_W'(IDX_LIM + w - W_LIM);
      end else if (w >= W_LINK && w < W_LINK + N_LINK) begin
        s.hit = 1'b1; s.idx = IDX_W'(IDX_LINK + w - W_LINK);
      end else if (w == W_RAMP) begin
        s.hit = 1'b1; s.idx = IDX_W'(IDX_RAMP);
      end
    end
    return s;
  endfunction

  function automatic slot_t entry_slot(input logic [ENT_W-1:0] e);
    slot_t s;
    int    n;
    s = '0;
    n = int'(e);
    if (n <= ENT_FREQ_TOP && n > ENT_FREQ_TOP - N_FREQ) begin
      s.hit = 1'b1; s.idx = IDX_W'(ENT_FREQ_TOP - n);
    end else if (n <= ENT_LIM_TOP && n > ENT_LIM_TOP - N_LIM) begin
      s.hit = 1'b1; s.idx = IDX_W'(IDX_LIM + ENT_LIM_TOP - n);
    end else if (n <= ENT_LINK_TOP && n > ENT_LINK_TOP - N_LINK) begin
      s.hit = 1'b1; s.idx = IDX_W'(IDX_LINK + ENT_LINK_TOP - n);
    end else if (n == ENT_RAMP) begin
      s.hit = 1'b1; s.idx = IDX_W'(IDX_RAMP);
    end
    return s;
  endfunction
endpackage

// File: rtl/rcfg_rst_sync.sv
`timescale 1ns/1ps
module rcfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/rcfg_cmd.sv
`timescale 1ns/1ps
module rcfg_cmd #(
  parameter int BUSY_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic wr_root_i,
  output logic root_o,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic          root_q, root_d, busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    root_d = root_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == CW'(BUSY_CYC - 1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    if (wr_en_i) begin
      root_d = wr_root_i;
      if (wr_root_i && !root_q) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      root_q <= root_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign root_o = root_q;
  assign busy_o = busy_q;

  AST_BUSY_FROM_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $rose(root_q)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(BUSY_CYC))); // R4
  AST_ROOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (root_q == $past(wr_root_i))); // R4
endmodule

// File: rtl/rcfg_update.sv
`timescale 1ns/1ps
module rcfg_update
  import rcfg_pkg::*;
#(
  parameter int ACK_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_go_i,
  input  logic [ENT_W-1:0] wr_ent_i,
  output logic             en_o,
  output logic [ENT_W-1:0] ent_o,
  output logic [ACK_W-1:0] ack_o,
  output logic             commit_o,
  output logic [ENT_W-1:0] commit_ent_o
);
  localparam int CW = $clog2(ACK_LAT + 1);

  logic             en_q, en_d, wait_q, wait_d, fire;
  logic [ENT_W-1:0] ent_q, ent_d, pend_q, pend_d;
  logic [ACK_W-1:0] ack_q, ack_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign fire = wr_en_i && wr_go_i && !en_q;

  always_comb begin
    en_d   = en_q;
    ent_d  = ent_q;
    pend_d = pend_q;
    ack_d  = ack_q;
    wait_d = wait_q;
    cnt_d  = cnt_q;
    if (wait_q) begin
      if (cnt_q == CW'(ACK_LAT - 1)) begin
        ack_d  = ACK_W'(1) << pend_q;
        wait_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    if (wr_en_i) begin
      en_d  = wr_go_i;
      ent_d = wr_ent_i;
      if (!wr_go_i) begin
        ack_d  = '0;
        wait_d = 1'b0;
        cnt_d  = '0;
      end
      if (fire) begin
        ack_d  = '0;
        wait_d = 1'b1;
        cnt_d  = '0;
        pend_d = wr_ent_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ent_q  <= '0;
      pend_q <= '0;
      ack_q  <= '0;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      ent_q  <= ent_d;
      pend_q <= pend_d;
      ack_q  <= ack_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_o         = en_q;
  assign ent_o        = ent_q;
  assign ack_o        = ack_q;
  assign commit_o     = fire;
  assign commit_ent_o = wr_ent_i;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q)); // R7
  AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ack_q) |-> $past(wait_q)); // R7
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_q) |-> en_q); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_go_i) |=> (ack_q == '0)); // R8
  AST_REWRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_go_i && en_q) |=> $stable(pend_q)); // R9
endmodule

// File: rtl/rcfg_shadow.sv
`timescale 1ns/1ps
module rcfg_shadow
  import rcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     commit_i,
  input  logic [ENT_W-1:0]         commit_ent_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [N_WORD*DATA_W-1:0] cfg_commit_o
);
  logic [DATA_W-1:0] sh_q [N_WORD];
  logic [DATA_W-1:0] sh_d [N_WORD];
  logic [DATA_W-1:0] cm_q [N_WORD];
  logic [DATA_W-1:0] cm_d [N_WORD];
  slot_t             cslot;

  assign cslot = entry_slot(commit_ent_i);

  always_comb begin
    for (int k = 0; k < N_WORD; k++) begin
      sh_d[k] = (wr_en_i && wr_idx_i == IDX_W'(k)) ? wr_data_i : sh_q[k];
      cm_d[k] = (commit_i && cslot.hit && cslot.idx == IDX_W'(k)) ? sh_q[k] : cm_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_WORD; k++) begin
        sh_q[k] <= '0;
        cm_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_WORD; k++) begin
        sh_q[k] <= sh_d[k];
        cm_q[k] <= cm_d[k];
      end
    end
  end

  assign rd_data_o = (rd_idx_i < IDX_W'(N_WORD)) ? sh_q[rd_idx_i] : '0;

  for (genvar k = 0; k < N_WORD; k++) begin : g_word
    assign cfg_commit_o[k*DATA_W +: DATA_W] = cm_q[k];

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && cslot.hit && cslot.idx == IDX_W'(k)) |=> (cm_q[k] == $past(sh_q[k]))); // R6
  end

  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(cfg_commit_o)); // R11
endmodule

// File: rtl/ramp_cfg_regs.sv
`timescale 1ns/1ps
module ramp_cfg_regs
  import rcfg_pkg::*;
#(
  parameter int BUSY_CYC = 6,
  parameter int ACK_LAT  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [N_WORD*DATA_W-1:0] cfg_commit
);
  logic              rst_s_n;
  logic              wr, rd, hit_cmd, hit_upd, mapped;
  slot_t             aslot;
  logic              root, busy, upd_en, commit;
  logic [ENT_W-1:0]  upd_ent, commit_ent;
  logic [ACK_W-1:0]  ack;
  logic [DATA_W-1:0] sh_rd, rd_mux, rsp_d, rsp_q;
  logic              rsp_valid_q;

  rcfg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_s_n));

  assign req_ready = 1'b1;
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign aslot     = addr_slot(req_addr);
  assign hit_cmd   = (req_addr == ADDR_W'(OFF_CMD));
  assign hit_upd   = (req_addr == ADDR_W'(OFF_UPD));
  assign mapped    = hit_cmd || hit_upd || aslot.hit;

  rcfg_cmd #(.BUSY_CYC(BUSY_CYC)) u_cmd (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en_i(wr && hit_cmd), .wr_root_i(req_wdata[1]),
    .root_o(root), .busy_o(busy)
  );

  rcfg_update #(.ACK_LAT(ACK_LAT)) u_upd (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en_i(wr && hit_upd), .wr_go_i(req_wdata[GO_BIT]),
    .wr_ent_i(req_wdata[ENT_W-1:0]),
    .en_o(upd_en), .ent_o(upd_ent), .ack_o(ack),
    .commit_o(commit), .commit_ent_o(commit_ent)
  );

  rcfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en_i(wr && aslot.hit), .wr_idx_i(aslot.idx), .wr_data_i(req_wdata),
    .commit_i(commit), .commit_ent_i(commit_ent),
    .rd_idx_i(aslot.idx), .rd_data_o(sh_rd),
    .cfg_commit_o(cfg_commit)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_cmd) begin
      rd_mux[1] = root;
      rd_mux[0] = busy;
    end else if (hit_upd) begin
      rd_mux[ACK_LSB +: ACK_W] = ack;
      rd_mux[GO_BIT]           = upd_en;
      rd_mux[ENT_W-1:0]        = upd_ent;
    end else if (aslot.hit) begin
      rd_mux = sh_rd;
    end
    rsp_d = rd ? rd_mux : rsp_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= rd;
      rsp_q       <= rsp_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd |=> rsp_valid); // R2
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> $past(rd)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd && !mapped) |=> (rsp_rdata == '0)); // R3
  AST_UNMAPPED_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr && !mapped) |=> $stable(cfg_commit)); // R3
endmodule

// File: tb/ramp_cfg_regs_test.sv
`timescale 1ns/1ps
module ramp_cfg_regs_test;
  localparam int BUSY_CYC = 6;
  localparam int ACK_LAT  = 4;
  localparam int NW       = 13;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, req_ready, rsp_valid;
  logic [6:0]   req_addr;
  logic [31:0]  req_wdata, rsp_rdata;
  logic [NW*32-1:0] cfg_commit;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [31:0] m_sh [NW];
  logic [31:0] m_cm [NW];
  logic        m_root, m_en;
  logic [3:0]  m_ent;
  logic [15:0] m_ack;

  ramp_cfg_regs #(.BUSY_CYC(BUSY_CYC), .ACK_LAT(ACK_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_commit(cfg_commit)
  );

  always #4 clk = ~clk;

  function automatic int addr_to_idx(input logic [6:0] a);
    int w;
    w = int'(a[6:2]);
    if (a[1:0] != 2'b00) return -1;
    if (w >= 4 && w <= 11) return w - 4;
    if (w >= 12 && w <= 14) return 8 + (w - 12);
    if (w == 16) return 11;
    if (w == 20) return 12;
    return -1;
  endfunction

  function automatic int entry_to_idx(input logic [3:0] e);
    int n;
    n = int'(e);
    if (n >= 7 && n <= 14) return 14 - n;
    if (n >= 4 && n <= 6) return 8 + (6 - n);
    if (n == 3) return 11;
    if (n == 2) return 12;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(input logic [6:0] a);
    int ix;
    if (a == 7'h00) return {30'd0, m_root, 1'b0};
    if (a == 7'h60) return {m_ack, 7'd0, m_en, 4'd0, m_ent};
    ix = addr_to_idx(a);
    if (ix >= 0) return m_sh[ix];
    return 32'd0;
  endfunction

  function automatic logic [31:0] upd_val(input logic [15:0] ack, input logic en, input logic [3:0] ent);
    return {ack, 7'd0, en, 4'd0, ent};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a == 7'h60) begin
      if (!d[8]) m_ack = '0;
      if (d[8] && !m_en) begin
        m_ack = '0;
        if (entry_to_idx(d[3:0]) >= 0) m_cm[entry_to_idx(d[3:0])] = m_sh[entry_to_idx(d[3:0])];
      end
      m_en = d[8]; m_ent = d[3:0];
    end else if (a == 7'h00) begin
      m_root = d[1];
    end else if (addr_to_idx(a) >= 0) begin
      m_sh[addr_to_idx(a)] = d;
    end
  endtask

  task automatic do_read(input logic [6:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    nchk++;
    if (rsp_valid !== 1'b1) begin
      nerr++;
      $display("FAIL R2: rsp_valid got %b expected 1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic chk_commit(input string req);
    for (int k = 0; k < NW; k++) chk(req, cfg_commit[k*32 +: 32], m_cm[k]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv;
    int unsigned sd;
    sd = $urandom(32'd4242);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    m_root = 1'b0; m_en = 1'b0; m_ent = '0; m_ack = '0;
    for (int k = 0; k < NW; k++) begin m_sh[k] = '0; m_cm[k] = '0; end
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk_commit("R1 commit");
    do_read(7'h00, rv); chk("R1 cmd", rv, 32'd0);
    do_read(7'h60, rv); chk("R1 upd", rv, 32'd0);
    do_read(7'h50, rv); chk("R1 ramp", rv, 32'd0);

    // R2 shadow words read back
    for (int w = 0; w < 32; w++) begin
      if (addr_to_idx(7'(w * 4)) >= 0) do_write(7'(w * 4), $urandom);
    end
    for (int w = 0; w < 32; w++) begin
      if (addr_to_idx(7'(w * 4)) >= 0) begin
        do_read(7'(w * 4), rv); chk("R2 shadow", rv, model_read(7'(w * 4)));
      end
    end

    // R3 unmapped and unaligned
    begin
      logic [6:0] um [17];
      um = '{7'h04, 7'h08, 7'h0C, 7'h3C, 7'h44, 7'h48, 7'h4C, 7'h54, 7'h58,
             7'h5C, 7'h64, 7'h68, 7'h6C, 7'h7C, 7'h11, 7'h52, 7'h63};
      for (int i = 0; i < 17; i++) do_write(um[i], 32'hFFFF_FFFF);
      for (int i = 0; i < 17; i++) begin
        do_read(um[i], rv); chk("R3 unmapped read", rv, 32'd0);
      end
      do_read(7'h10, rv); chk("R3 neighbour", rv, m_sh[0]);
      do_read(7'h50, rv); chk("R3 neighbour", rv, m_sh[12]);
      do_read(7'h60, rv); chk("R3 upd untouched", rv, 32'd0);
      do_read(7'h00, rv); chk("R3 cmd untouched", rv, 32'd0);
      chk_commit("R3 commit untouched");
    end

    // R4 root enable and busy window
    do_write(7'h00, 32'h2);
    for (int k = 1; k <= BUSY_CYC + 1; k++) begin
      do_read(7'h00, rv); chk("R4 busy window", rv, (k <= BUSY_CYC) ? 32'd3 : 32'd2);
    end
    do_write(7'h00, 32'hFFFF_FFFF);
    do_read(7'h00, rv); chk("R4 no restart", rv, 32'd2);
    do_write(7'h00, 32'h0);
    do_read(7'h00, rv); chk("R4 root clear", rv, 32'd0);

    // R5 update register layout
    do_write(7'h60, 32'hFFFF_0EF5);
    do_read(7'h60, rv); chk("R5 layout", rv, 32'h0000_0005);
    do_write(7'h60, 32'h0);
    do_read(7'h60, rv); chk("R5 clear", rv, 32'd0);

    // R6 + R7 commit entry 14, ack timing
    do_write(7'h60, 32'h10E);
    chk_commit("R6 commit entry 14");
    for (int k = 1; k <= ACK_LAT + 2; k++) begin
      do_read(7'h60, rv);
      chk("R7 ack timing", rv, upd_val((k >= ACK_LAT + 1) ? 16'h4000 : 16'h0, 1'b1, 4'hE));
    end
    // R8 clear drops ack
    do_write(7'h60, 32'h0);
    do_read(7'h60, rv); chk("R8 ack dropped", rv, 32'd0);

    // R9 rewrite while enabled
    do_write(7'h60, 32'h10D);
    do_read(7'h60, rv); chk("R9 before rewrite", rv, upd_val(16'h0, 1'b1, 4'hD));
    do_write(7'h60, 32'h10C);
    chk_commit("R9 no recommit");
    for (int k = 3; k <= ACK_LAT + 2; k++) begin
      do_read(7'h60, rv);
      chk("R9 ack keeps entry", rv, upd_val((k >= ACK_LAT + 1) ? 16'h2000 : 16'h0, 1'b1, 4'hC));
    end
    do_write(7'h60, 32'h0);

    // R8 cancel of a pending ack
    do_write(7'h60, 32'h107);
    do_write(7'h60, 32'h0);
    chk_commit("R8 copy kept");
    for (int k = 2; k <= ACK_LAT + 3; k++) begin
      do_read(7'h60, rv); chk("R8 cancelled", rv, 32'd0);
    end

    // R10 entries with no word
    begin
      logic [3:0] nw [3];
      nw = '{4'h0, 4'h1, 4'hF};
      for (int i = 0; i < 3; i++) begin
        do_write(7'h60, {23'd0, 1'b1, 4'd0, nw[i]});
        chk_commit("R10 no change");
        idle(ACK_LAT);
        do_read(7'h60, rv);
        chk("R10 ack", rv, upd_val(16'(1) << nw[i], 1'b1, nw[i]));
        do_write(7'h60, 32'h0);
      end
    end

    // R6 ramp entry 2, then R11 hold after shadow change
    do_write(7'h60, 32'h102);
    chk_commit("R6 ramp entry");
    do_write(7'h60, 32'h0);
    do_write(7'h50, 32'hA5A5_5A5A);
    do_write(7'h10, 32'h1234_5678);
    chk_commit("R11 hold");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int sel;
      sel = int'($urandom % 3);
      if (sel == 0) begin
        do_write(7'(($urandom % 32) * 4), $urandom);
      end else if (sel == 1) begin
        logic [3:0] e;
        e = 4'($urandom);
        do_write(7'h60, {23'd0, 1'b1, 4'd0, e});
        chk_commit("R6 random commit");
        idle(ACK_LAT);
        do_read(7'h60, rv);
        chk("R7 random ack", rv, upd_val(16'(1) << e, 1'b1, e));
        do_write(7'h60, 32'h0);
      end else begin
        logic [6:0] a;
        a = 7'($urandom);
        do_read(a, rv); chk("R2 R3 random read", rv, model_read(a));
      end
    end
    chk_commit("R11 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule